// File: doc/BRIEF.md
# Bit-Serial Word FIFO

This block is a synchronous first-in first-out buffer that holds a fixed number of words, each a fixed number of bits wide. Words do not cross the block's edge in parallel. A producer moves a word in one bit per enabled clock, least significant bit first. A consumer moves it out the same way. Each side keeps its own bit counter and entry pointer. A side's pointer steps to the next entry only on the enabled clock that carries the last bit of a word.

Full and empty are not stored as state. Both are derived from the two pointers and a single flag that records which kind of word transfer completed last. Because a read can only touch an entry that is already complete, and a write can only touch one that is free, the two sides run in the same cycles with no lock between them. A request on a side that is blocked is dropped, and the block raises a one-cycle error pulse.

Top module: `serial_word_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, overflow is 0 and underflow is 0.
- R2: A word is taken in over WIDTH clocks with wr_en high, least significant bit first on wr_bit. It is given out over WIDTH clocks with rd_en high, least significant bit first. While the buffer is not empty, rd_bit shows the current bit before the edge that consumes it. Words leave in the order they entered.
- R3: Clocks with wr_en or rd_en low hold that side's progress. A word may be spread over enabled clocks that are not consecutive.
- R4: empty stays 1 until the clock that carries the WIDTH-th bit of a word. It reads 0 from the cycle after that clock.
- R5: After DEPTH complete words and no reads, full is 1 and empty is 0. The two are never 1 together.
- R6: wr_en high while full is ignored. The stored contents and the word count do not change, and overflow is 1 in the following cycle only.
- R7: rd_en high while empty is ignored, and underflow is 1 in the following cycle only. A later write and read still work normally.
- R8: full stays 1 during a partial read. It clears in the cycle after the clock that carries the read's WIDTH-th bit.
- R9: A write into one entry and a read from another may run in the same clocks. When both words complete on the same edge, empty and full keep their values and no data is disturbed.
- R10: Both pointers wrap after DEPTH entries in the same direction. More than DEPTH words passed through over time come out intact and in order.
- R11: While empty is 1, rd_bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Shift one bit in this clock |
| wr_bit | input | 1 | Serial data in, LSB first |
| rd_en | input | 1 | Consume the shown bit this clock |
| rd_bit | output | 1 | Serial data out, LSB first, 0 when empty |
| empty | output | 1 | No complete word is stored |
| full | output | 1 | DEPTH complete words are stored |
| overflow | output | 1 | One-cycle pulse after a write request while full |
| underflow | output | 1 | One-cycle pulse after a read request while empty |

## Verification
The hardest case to reach is two words finishing on the same edge, one on each side. That is the only moment when the last-operation flag must keep its value. To reach it, the stimulus first stores one complete word. It then starts a write and a read at the same negative edge and lets both run for exactly WIDTH clocks in parallel. The bench also checks full and empty one bit short of a word boundary. It sends long word streams so that both pointers wrap more than once.

// File: rtl/swf_pkg.sv
package swf_pkg;

   typedef enum logic [0:0] {
      PTR_UP   = 1'b0,
      PTR_DOWN = 1'b1
   } ptr_dir_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/swf_side_ctrl.sv
module swf_side_ctrl #(
   parameter int unsigned      DEPTH = 4,
   parameter int unsigned      WIDTH = 8,
   parameter swf_pkg::ptr_dir_e DIR  = swf_pkg::PTR_UP,
   localparam int unsigned     PW    = swf_pkg::idx_bits(DEPTH),
   localparam int unsigned     CW    = swf_pkg::idx_bits(WIDTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          blocked,
   output logic [PW-1:0] ptr,
   output logic [CW-1:0] cnt,
   output logic          step,
   output logic          done
);

   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
   localparam logic [CW-1:0] LAST_BIT = CW'(WIDTH - 1);

   logic [PW-1:0] ptr_nxt;

   assign step = req & ~blocked;
   assign done = step & (cnt == LAST_BIT);

   generate
      if (DIR == swf_pkg::PTR_UP) begin : g_up
         always_comb begin
            if (ptr == LAST_IDX) ptr_nxt = '0;
            else                 ptr_nxt = ptr + PW'(1);
         end
      end else begin : g_down
         always_comb begin
            if (ptr == '0) ptr_nxt = LAST_IDX;
            else           ptr_nxt = ptr - PW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (step) begin
         if (done) cnt <= '0;
         else      cnt <= cnt + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (done) ptr <= ptr_nxt;
   end

endmodule

// File: rtl/swf_store.sv
module swf_store #(
   parameter int unsigned  DEPTH = 4,
   parameter int unsigned  WIDTH = 8,
   localparam int unsigned PW    = swf_pkg::idx_bits(DEPTH),
   localparam int unsigned CW    = swf_pkg::idx_bits(WIDTH)
) (
   input  logic          clk,
   input  logic          wr_step,
   input  logic [PW-1:0] wr_ptr,
   input  logic [CW-1:0] wr_cnt,
   input  logic          wr_bit,
   input  logic [PW-1:0] rd_ptr,
   input  logic [CW-1:0] rd_cnt,
   output logic          rd_bit_raw
);

   logic [DEPTH-1:0][WIDTH-1:0] rows;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic [WIDTH-1:0] row_q;
         logic             sel;
         assign sel = wr_step & (wr_ptr == PW'(e));
         for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            always_ff @(posedge clk) begin
               if (sel && (wr_cnt == CW'(b))) row_q[b] <= wr_bit;
            end
         end
         assign rows[e] = row_q;
      end
   endgenerate

   assign rd_bit_raw = rows[rd_ptr][rd_cnt];

endmodule

// File: rtl/swf_status.sv
module swf_status #(
   parameter int unsigned  DEPTH = 4,
   localparam int unsigned PW    = swf_pkg::idx_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_done,
   input  logic          rd_done,
   input  logic [PW-1:0] wr_ptr,
   input  logic [PW-1:0] rd_ptr,
   output logic          empty,
   output logic          full
);

   logic last_was_wr;
   logic same_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     last_was_wr <= 1'b0;
      else if (wr_done && !rd_done)   last_was_wr <= 1'b1;
      else if (rd_done && !wr_done)   last_was_wr <= 1'b0;
   end

   assign same_idx = (wr_ptr == rd_ptr);
   assign empty    = same_idx & ~last_was_wr;
   assign full     = same_idx &  last_was_wr;

endmodule

// File: rtl/serial_word_fifo.sv
module serial_word_fifo #(
   parameter int unsigned       DEPTH = 4,
   parameter int unsigned       WIDTH = 8,
   parameter swf_pkg::ptr_dir_e DIR   = swf_pkg::PTR_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic rd_en,
   output logic rd_bit,
   output logic empty,
   output logic full,
   output logic overflow,
   output logic underflow
);

   localparam int unsigned PW = swf_pkg::idx_bits(DEPTH);
   localparam int unsigned CW = swf_pkg::idx_bits(WIDTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("serial_word_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("serial_word_fifo: WIDTH must be at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] wr_cnt, rd_cnt;
   logic          wr_step, rd_step, wr_done, rd_done;
   logic          rd_bit_raw;

   swf_side_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DIR(DIR)) u_wr_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wr_en),
      .blocked (full),
      .ptr     (wr_ptr),
      .cnt     (wr_cnt),
      .step    (wr_step),
      .done    (wr_done)
   );

   swf_side_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DIR(DIR)) u_rd_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (rd_en),
      .blocked (empty),
      .ptr     (rd_ptr),
      .cnt     (rd_cnt),
      .step    (rd_step),
      .done    (rd_done)
   );

   swf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk        (clk),
      .wr_step    (wr_step),
      .wr_ptr     (wr_ptr),
      .wr_cnt     (wr_cnt),
      .wr_bit     (wr_bit),
      .rd_ptr     (rd_ptr),
      .rd_cnt     (rd_cnt),
      .rd_bit_raw (rd_bit_raw)
   );

   swf_status #(.DEPTH(DEPTH)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_done (wr_done),
      .rd_done (rd_done),
      .wr_ptr  (wr_ptr),
      .rd_ptr  (rd_ptr),
      .empty   (empty),
      .full    (full)
   );

   logic rd_step_unused;
   assign rd_step_unused = rd_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         overflow  <= wr_en & full;
         underflow <= rd_en & empty;
      end
   end

   assign rd_bit = rd_bit_raw & ~empty;

endmodule

// File: rtl/serial_word_fifo_chk.sv
module serial_word_fifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic rd_en,
   input logic rd_bit,
   input logic empty,
   input logic full,
   input logic overflow,
   input logic underflow
);

   a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   a_r6_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> overflow);

   a_r6_full_holds_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);

   a_r7_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> underflow);

   a_r4_empty_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_en) |=> empty);

   a_r11_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_bit);

endmodule

bind serial_word_fifo serial_word_fifo_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .rd_bit    (rd_bit),
   .empty     (empty),
   .full      (full),
   .overflow  (overflow),
   .underflow (underflow)
);

// File: tb/serial_word_fifo_bench.sv
module serial_word_fifo_bench;

   localparam int unsigned DEPTH = 4;
   localparam int unsigned WIDTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
   logic rd_bit, empty, full, overflow, underflow;

   int checks = 0;
   int errors = 0;
   logic [WIDTH-1:0] model_q[$];

   always #4 clk = ~clk;

   serial_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_serial_word_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
      .rd_bit(rd_bit), .empty(empty), .full(full),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WIDTH-1:0] pattern(input int k);
      return WIDTH'((k * 37 + 11) ^ (k << 3));
   endfunction

   task automatic write_word(input logic [WIDTH-1:0] w);
      for (int b = 0; b < WIDTH; b++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_bit = w[b];
      end
      @(negedge clk);
      wr_en = 1'b0;
      model_q.push_back(w);
   endtask

   task automatic read_word(input string req);
      logic [WIDTH-1:0] got;
      logic [WIDTH-1:0] exp;
      for (int b = 0; b < WIDTH; b++) begin
         @(negedge clk);
         rd_en = 1'b1;
         #1 got[b] = rd_bit;
      end
      @(negedge clk);
      rd_en = 1'b0;
      exp = (model_q.size() > 0) ? model_q.pop_front() : '0;
      check(req, 32'(got), 32'(exp));
   endtask

   task automatic t_reset;
      check("R1 empty", 32'(empty), 1);
      check("R1 full", 32'(full), 0);
      check("R1 overflow", 32'(overflow), 0);
      check("R1 underflow", 32'(underflow), 0);
   endtask

   task automatic t_basic;
      write_word(8'hA5);
      write_word(8'h3C);
      read_word("R2 first word");
      read_word("R2 second word");
      check("R2 empty after drain", 32'(empty), 1);
   endtask

   task automatic t_partial_and_gaps;
      logic [WIDTH-1:0] w = 8'h96;
      for (int b = 0; b < WIDTH - 1; b++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_bit = w[b];
         @(negedge clk);
         wr_en = 1'b0;
      end
      repeat (3) @(negedge clk);
      check("R4 empty one bit short", 32'(empty), 1);
      check("R3 gapped write held", 32'(full), 0);
      wr_en = 1'b1;
      wr_bit = w[WIDTH-1];
      @(negedge clk);
      wr_en = 1'b0;
      check("R4 empty clears after last bit", 32'(empty), 0);
      model_q.push_back(w);
      read_word("R3 gapped word readback");
   endtask

   task automatic t_underflow;
      check("R11 rd_bit zero when empty", 32'(rd_bit), 0);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R7 underflow pulse", 32'(underflow), 1);
      @(negedge clk);
      check("R7 underflow one cycle", 32'(underflow), 0);
      check("R7 still empty", 32'(empty), 1);
      write_word(8'h5A);
      read_word("R7 normal after underflow");
   endtask

   task automatic t_full_overflow;
      for (int k = 0; k < DEPTH; k++) write_word(pattern(k));
      check("R5 full", 32'(full), 1);
      check("R5 not empty", 32'(empty), 0);
      @(negedge clk);
      wr_en = 1'b1;
      wr_bit = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 overflow pulse", 32'(overflow), 1);
      @(negedge clk);
      check("R6 overflow one cycle", 32'(overflow), 0);
      check("R6 still full", 32'(full), 1);
      for (int b = 0; b < WIDTH - 1; b++) begin
         @(negedge clk);
         rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
      check("R8 full during partial read", 32'(full), 1);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R8 full clears after last bit", 32'(full), 0);
      void'(model_q.pop_front());
      for (int k = 1; k < DEPTH; k++) read_word("R6 contents unchanged");
      check("R6 no extra word", 32'(empty), 1);
   endtask

   task automatic t_concurrent;
      logic e0, f0;
      write_word(8'hC3);
      e0 = empty;
      f0 = full;
      fork
         read_word("R9 concurrent read data");
         begin
            logic [WIDTH-1:0] w = 8'h71;
            for (int b = 0; b < WIDTH; b++) begin
               @(negedge clk);
               wr_en = 1'b1;
               wr_bit = w[b];
            end
            @(negedge clk);
            wr_en = 1'b0;
         end
      join
      model_q.push_back(8'h71);
      check("R9 empty unchanged", 32'(empty), 32'(e0));
      check("R9 full unchanged", 32'(full), 32'(f0));
      read_word("R9 concurrent write data");
   endtask

   task automatic t_wrap;
      for (int k = 0; k < 3 * DEPTH; k++) begin
         write_word(pattern(k + 20));
         if (k % 2 == 1) begin
            read_word("R10 wrap order");
            read_word("R10 wrap order");
         end
      end
      check("R10 drained", 32'(empty), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_basic;
      t_partial_and_gaps;
      t_underflow;
      t_full_overflow;
      t_concurrent;
      t_wrap;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule